// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Host Controller

This block sits between a synchronous on-chip requester and an external asynchronous pseudo-static RAM of 512K words by 16 bits. A requester hands it a read or a write with a word address, write data and per-byte lane enables through a valid/ready handshake. The block then plays out the memory strobe sequence. It counts every timing minimum in system clock cycles and returns read data with a one-cycle done pulse.

Every access is framed by chip enable, and chip enable goes high again between commands. Reads are framed by chip enable: the address is placed on the pins one cycle before chip enable falls and is not changed until it rises. Writes raise write enable inside a chip-enable window. The block keeps driving the data bus for at least one cycle after write enable rises. The memory needs its internal refresh to make progress. A selection watchdog therefore measures how long the memory has gone without a chip-enable-high interval of at least one read cycle time. Once that span reaches its limit, the block stretches the next gap between commands to a full read cycle time.

The tri-state pad is outside the block. It exposes the outgoing data, the incoming data and a driver enable.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is applied and after it is released, chip enable, output enable, write enable and both lane strobes are high, the data driver enable is low, cmd_ready is high and rsp_done is low.
- R2: cmd_ready is high only when no command is in progress, and a command is taken on a clock edge where cmd_valid and cmd_ready are both high. rsp_done is a single-cycle pulse, one per command, in command order. cmd_ready is low in the cycle after acceptance.
- R3: A read places the address one cycle before chip enable falls and holds it while chip enable is low. Chip enable and output enable stay low for T_RC cycles with write enable high. rsp_done rises 1+T_RC clock edges after the accepting edge.
- R4: cmd_be bit 0 selects data bits 7:0 and bit 1 selects bits 15:8. A read returns the memory data sampled in the last output-enable-low cycle on selected lanes and zero on unselected lanes.
- R5: A write holds chip enable low for T_AS cycles before write enable falls, then holds write enable low for T_WP cycles. It keeps chip enable low for max(1, T_WC-T_AS-T_WP) cycles after write enable rises. Output enable stays high throughout, and rsp_done rises 1+T_AS+T_WP+max(1,T_WC-T_AS-T_WP) edges after acceptance.
- R6: A lane strobe is low only while chip enable is low and only for a lane enabled in the command. A write with both lanes disabled leaves memory unchanged.
- R7: The data driver is off in every cycle with output enable low. It is on in every cycle with write enable low and in the cycle where write enable rises.
- R8: Between two commands chip enable stays high for at least max(T_GAP,T_TURN)+2 cycles.
- R9: The selection span is the number of cycles since the last chip-enable-high run of T_RC cycles or more. Once it reaches T_WDOG, the gap after the command in progress keeps chip enable high for at least T_RC cycles, so the span never exceeds T_WDOG by more than one command plus one gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 19 | Word address |
| cmd_wdata | input | 16 | Write data |
| cmd_be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8, active high |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done on reads |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_be_n | output | 2 | Lane strobes, bit 0 lower, bit 1 upper, active low |
| mem_addr | output | 19 | Memory address pins |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_i | input | 16 | Data from the memory pad |
| mem_dq_oe | output | 1 | Data pad driver enable |

## Verification
A read's done pulse is due 1+T_RC edges after the accepting edge. A write's done pulse is due 1+T_AS+T_WP+max(1,T_WC-T_AS-T_WP) edges after it. The driver records the edge count at acceptance together with the expected data and lane-masked value, and the monitor compares both the edge count and the data when the pulse appears. Strobe relations, driver direction, gap widths and the selection span are sampled on the falling clock edge, half a cycle after the registers that set them have settled.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RD,
    ST_WR_AS,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_GAP
  } psram_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_phase_cnt.sv
module psram_phase_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         last_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = val_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/psram_selwdog.sv
module psram_selwdog #(
  parameter int T_RC   = 3,
  parameter int T_WDOG = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n_i,
  output logic long_gap_o
);

  localparam int HW = $clog2(T_RC + 1);
  localparam int SW = $clog2(T_WDOG + 1);

  logic [HW-1:0] hi_q, hi_d;
  logic [SW-1:0] span_q, span_d;

  always_comb begin
    if (!ce_n_i)                 hi_d = '0;
    else if (hi_q == HW'(T_RC))  hi_d = hi_q;
    else                         hi_d = hi_q + 1'b1;

    if (hi_d >= HW'(T_RC))           span_d = '0;
    else if (span_q == SW'(T_WDOG))  span_d = span_q;
    else                             span_d = span_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      span_q <= '0;
    end else begin
      hi_q   <= hi_d;
      span_q <= span_d;
    end
  end

  assign long_gap_o = (span_q >= SW'(T_WDOG));

  AST_SPAN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q == HW'(T_RC)) |-> (span_q == '0)); // R9

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int T_RC   = 3,
  parameter int T_WC   = 3,
  parameter int T_AS   = 1,
  parameter int T_WP   = 2,
  parameter int T_GAP  = 1,
  parameter int T_TURN = 1,
  parameter int T_WDOG = 750
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_write,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [DATA_W-1:0]   cmd_wdata,
  input  logic [DATA_W/8-1:0] cmd_be,
  output logic                rsp_done,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_ce_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dq_o,
  input  logic [DATA_W-1:0]   mem_dq_i,
  output logic                mem_dq_oe
);

  localparam int LANES   = DATA_W / 8;
  localparam int HOLD_C  = (T_WC > T_AS + T_WP + 1) ? (T_WC - T_AS - T_WP) : 1;
  localparam int GAP_C   = max2(max2(T_GAP, T_TURN), 1);
  localparam int LONG_C  = max2(T_RC, GAP_C);
  localparam int CNT_MAX = max2(max2(max2(T_RC, T_AS), max2(T_WP, HOLD_C)), LONG_C);
  localparam int CW      = $clog2(CNT_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  psram_state_e      state_q, state_d;
  logic              ld;
  logic [CW-1:0]     ld_val;
  logic              phase_last;
  logic              long_gap;
  logic              accept;
  logic              cap_en;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_masked;
  logic              done_q;
  logic              selected;

  psram_phase_cnt #(.W(CW)) u_phase (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (ld),
    .val_i  (ld_val),
    .last_o (phase_last)
  );

  psram_selwdog #(.T_RC(T_RC), .T_WDOG(T_WDOG)) u_selwdog (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ce_n_i     (mem_ce_n),
    .long_gap_o (long_gap)
  );

  assign accept = (state_q == ST_IDLE) && cmd_valid;
  assign cap_en = (state_q == ST_RD) && phase_last;

  // next state and phase length
  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      ST_IDLE: if (cmd_valid) begin
        state_d = ST_SETUP;
        ld      = 1'b1;
      end
      ST_SETUP: begin
        ld = 1'b1;
        if (wr_q) begin
          state_d = ST_WR_AS;
          ld_val  = CW'(T_AS - 1);
        end else begin
          state_d = ST_RD;
          ld_val  = CW'(T_RC - 1);
        end
      end
      ST_RD: if (phase_last) begin
        state_d = ST_GAP;
        ld      = 1'b1;
        ld_val  = long_gap ? CW'(LONG_C - 1) : CW'(GAP_C - 1);
      end
      ST_WR_AS: if (phase_last) begin
        state_d = ST_WR_PULSE;
        ld      = 1'b1;
        ld_val  = CW'(T_WP - 1);
      end
      ST_WR_PULSE: if (phase_last) begin
        state_d = ST_WR_HOLD;
        ld      = 1'b1;
        ld_val  = CW'(HOLD_C - 1);
      end
      ST_WR_HOLD: if (phase_last) begin
        state_d = ST_GAP;
        ld      = 1'b1;
        ld_val  = long_gap ? CW'(LONG_C - 1) : CW'(GAP_C - 1);
      end
      ST_GAP: if (phase_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // lane masking of returned data
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rd_masked[8*i +: 8] = be_q[i] ? mem_dq_i[8*i +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q != ST_GAP) && (state_d == ST_GAP);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      wr_q    <= cmd_write;
      addr_q  <= cmd_addr;
      wdata_q <= cmd_wdata;
      be_q    <= cmd_be;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (cap_en)  rdata_q <= rd_masked;
  end

  assign selected  = (state_q == ST_RD) || (state_q == ST_WR_AS) ||
                     (state_q == ST_WR_PULSE) || (state_q == ST_WR_HOLD);
  assign mem_ce_n  = !selected;
  assign mem_oe_n  = (state_q != ST_RD);
  assign mem_we_n  = (state_q != ST_WR_PULSE);
  assign mem_be_n  = selected ? ~be_q : '1;
  assign mem_dq_oe = (state_q == ST_WR_PULSE) || (state_q == ST_WR_HOLD);
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign cmd_ready = (state_q == ST_IDLE);
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n)); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_oe_n |-> !mem_dq_oe); // R7
  AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(mem_we_n) |-> mem_dq_oe); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_ce_n |-> $stable(mem_addr)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_done |=> !rsp_done); // R2
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_ready |-> (mem_ce_n && (mem_be_n == '1) && !mem_dq_oe)); // R8

endmodule

// File: tb/psram_ctrl_tb.sv
module psram_ctrl_tb;

  localparam int T_RC   = 4;
  localparam int T_WC   = 4;
  localparam int T_AS   = 1;
  localparam int T_WP   = 2;
  localparam int T_GAP  = 1;
  localparam int T_TURN = 1;
  localparam int T_WDOG = 30;
  localparam int HOLDN  = (T_WC - T_AS - T_WP > 1) ? (T_WC - T_AS - T_WP) : 1;
  localparam int GAPN   = (T_GAP > T_TURN) ? T_GAP : T_TURN;
  localparam int RD_LAT = 1 + T_RC;
  localparam int WR_LAT = 1 + T_AS + T_WP + HOLDN;
  localparam int SPAN_BOUND = T_WDOG + 2 * T_RC + 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [18:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [1:0]  cmd_be = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [18:0] mem_addr;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  psram_ctrl #(
    .T_RC(T_RC), .T_WC(T_WC), .T_AS(T_AS), .T_WP(T_WP),
    .T_GAP(T_GAP), .T_TURN(T_TURN), .T_WDOG(T_WDOG)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_be(cmd_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model, driven from the pins
  logic [15:0] mem_model [int];
  logic [15:0] shadow    [int];

  always_comb begin
    logic [15:0] w;
    w = mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)] : 16'h0000;
    mem_dq_i = 16'hA5A5;
    for (int i = 0; i < 2; i++)
      if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[i])
        mem_dq_i[8*i +: 8] = w[8*i +: 8];
  end

  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n) begin
      logic [15:0] w;
      check(mem_dq_oe, "R7", "driver on at write end", int'(mem_dq_oe), 1);
      w = mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)] : 16'h0000;
      for (int i = 0; i < 2; i++)
        if (!mem_be_n[i]) w[8*i +: 8] = mem_dq_o[8*i +: 8];
      mem_model[int'(mem_addr)] = w;
    end
  end

  // scoreboard
  typedef struct {
    bit          wr;
    logic [15:0] exp;
    int          due;
  } item_t;
  item_t sb_q[$];
  logic [1:0] cur_be = 2'b00;
  bit burst = 1'b0;

  task automatic issue(input bit wr, input logic [18:0] a,
                       input logic [15:0] d, input logic [1:0] be);
    item_t it;
    logic [15:0] s;
    int acc;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_be = be;
    cur_be = be;
    @(negedge clk);
    acc = cyc;
    cmd_valid = 1'b0;
    check(!cmd_ready, "R2", "ready low after accept", int'(cmd_ready), 0);
    s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    it.wr = wr;
    it.exp = 16'h0000;
    if (wr) begin
      for (int i = 0; i < 2; i++) if (be[i]) s[8*i +: 8] = d[8*i +: 8];
      shadow[int'(a)] = s;
      it.due = acc + WR_LAT;
    end else begin
      for (int i = 0; i < 2; i++) if (be[i]) it.exp[8*i +: 8] = s[8*i +: 8];
      it.due = acc + RD_LAT;
    end
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2", "done without command", 1, 0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (it.wr)
          check(cyc == it.due, "R5", "write done edge", cyc, it.due);
        else begin
          check(cyc == it.due, "R3", "read done edge", cyc, it.due);
          check(rsp_rdata == it.exp, "R4", "read data", int'(rsp_rdata), int'(it.exp));
        end
      end
    end
  end

  // pin protocol monitors
  int hi_run = 100;
  int span = 0;
  int max_span = 0;
  int long_gaps = 0;

  always @(negedge clk) begin
    if (rst_n && cyc > 8) begin
      if (!mem_we_n) begin
        check(!mem_ce_n && mem_oe_n, "R5", "write strobe framing",
              int'({mem_ce_n, mem_oe_n}), 1);
        check(mem_dq_oe, "R7", "driver on while write low", int'(mem_dq_oe), 1);
      end
      if (!mem_oe_n) begin
        check(!mem_dq_oe, "R7", "driver off while output enabled", int'(mem_dq_oe), 0);
        check(mem_we_n, "R3", "write high during read", int'(mem_we_n), 1);
      end
      if (!mem_ce_n)
        check(mem_be_n == ~cur_be, "R6", "lane strobes", int'(mem_be_n), int'(~cur_be));
      else
        check(mem_be_n == 2'b11, "R6", "lanes idle", int'(mem_be_n), 3);
      if (!mem_ce_n && hi_run > 0) begin
        check(hi_run >= GAPN + 2, "R8", "deselect gap", hi_run, GAPN + 2);
        if (burst && hi_run >= T_RC) long_gaps++;
      end
      if (mem_ce_n) hi_run++; else hi_run = 0;
      if (hi_run >= T_RC) span = 0; else span++;
      if (span > max_span) max_span = span;
    end
  end

  initial begin
    wait (cyc == 60000);
    check(1'b0, "R2", "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe,
          "R1", "strobes in reset", int'({mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe}), 8'h3e);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe,
          "R1", "strobes after reset", int'({mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe}), 8'h3e);
    check(cmd_ready && !rsp_done, "R1", "handshake after reset",
          int'({cmd_ready, rsp_done}), 2);

    issue(1'b1, 19'h00010, 16'h1234, 2'b11);
    issue(1'b0, 19'h00010, 16'h0000, 2'b11);  // R3 full read
    issue(1'b1, 19'h00010, 16'hABCD, 2'b01);  // R6 lower lane only
    issue(1'b0, 19'h00010, 16'h0000, 2'b11);
    issue(1'b1, 19'h00010, 16'h5600, 2'b10);  // R6 upper lane only
    issue(1'b0, 19'h00010, 16'h0000, 2'b10);  // R4 lower masked
    issue(1'b0, 19'h00010, 16'h0000, 2'b01);  // R4 upper masked
    issue(1'b1, 19'h00010, 16'hFFFF, 2'b00);  // R6 no lanes, no change
    issue(1'b0, 19'h00010, 16'h0000, 2'b11);
    issue(1'b1, 19'h7FFFF, 16'hC3A1, 2'b11);
    issue(1'b1, 19'h00000, 16'h0F0F, 2'b11);
    issue(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
    issue(1'b0, 19'h00000, 16'h0000, 2'b11);

    // R9 continuous read burst
    burst = 1'b1;
    max_span = 0;
    for (int k = 0; k < 30; k++)
      issue(1'b0, 19'(k % 4 == 0 ? 19'h00010 : 19'h7FFFF - k), 16'h0000, 2'b11);
    repeat (12) @(negedge clk);
    burst = 1'b0;
    check(long_gaps > 0, "R9", "long deselect inserted", long_gaps, 1);
    check(max_span <= SPAN_BOUND, "R9", "selection span bound", max_span, SPAN_BOUND);
    check(sb_q.size() == 0, "R2", "all commands completed", sb_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule